// File: doc/BRIEF.md
# Interrupt Redirection Register File

This block is the register file of an interrupt routing unit. Software reaches it through two bus locations: an 8-bit select register, and a 32-bit data window that opens whichever internal register the select names. The internal space holds a 4-bit unit identifier, a constant version word, a read-only mirror of the identifier, and a table of 24 redirection entries. Each entry is 64 bits wide and is reached as two 32-bit halves.

Every entry is exported field by field to the interrupt delivery logic, which decides when and where each interrupt goes. That logic reports back through side-band inputs. Per entry it can set or clear the remote-IRR flag, and it drives a busy input that the entry shows as its delivery status bit. Software cannot write either status bit. Switching an entry to edge trigger clears its remote-IRR flag.

Bus writes commit on the clock edge where `bus_valid_i` and `bus_write_i` are both high. Read data is combinational: it reflects the addressed location and the current select value.

Top module: `irq_redir_regs`

## Requirements
- R1: Bus offset 0x00 holds the 8-bit select value. A write with `bus_be_i[0]` set loads `bus_wdata_i[7:0]`, and a read returns it in bits 7:0 with the upper bits zero. Offset 0x04, and every offset other than 0x00 and 0x10, reads as zero and ignores writes.
- R2: With select 0x01, the window reads 0x00170011, and writes through the window leave that value unchanged.
- R3: With select 0x00, a window write stores only bits 27:24 of the word. A window read with select 0x00 or select 0x02 returns that 4-bit ID in bits 27:24, with all other bits zero. Writes with select 0x02 are ignored.
- R4: Entry n's low word is at select 0x10+2n and its high word at select 0x11+2n. Select bit 0 chooses the high half.
- R5: A select below 0x10 other than 0x00–0x02 reads as zero and ignores writes. A select whose entry index is 24 or more reads as 0xFFFFFFFF and ignores writes.
- R6: The low word holds vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote IRR 14, trigger mode 15 (1 = level) and mask 16, with bits 31:17 reading zero. The high word holds the destination ID in bits 31:24 (entry bits 63:56), with bits 23:0 reading zero. Each field appears on its per-entry output port on the cycle after the write.
- R7: A low-word write keeps the stored delivery status and remote IRR bits. If the written trigger bit is 0 (edge), remote IRR is cleared.
- R8: After reset, every entry has mask = 1 and all other fields zero. The select and the ID are zero.
- R9: A window write takes effect only when `bus_be_i` is 4'hF. A write with any other byte-enable pattern leaves the target unchanged.
- R10: `rirr_set_i[n]` sets entry n's remote IRR and `rirr_clr_i[n]` clears it, with set winning when both are high. Both take priority over a same-cycle edge-mode low-word write.
- R11: The delivery status bit of entry n shows `busy_i[n]` as registered on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_be_i | input | 4 | Byte enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| rirr_set_i | input | 24 | Per-entry remote IRR set |
| rirr_clr_i | input | 24 | Per-entry remote IRR clear |
| busy_i | input | 24 | Per-entry delivery busy |
| vector_o | output | 24x8 | Entry vectors |
| dlv_mode_o | output | 24x3 | Entry delivery modes |
| dest_mode_o | output | 24 | Entry destination modes |
| polarity_o | output | 24 | Entry polarities |
| level_o | output | 24 | Entry trigger modes, 1 = level |
| mask_o | output | 24 | Entry masks |
| rirr_o | output | 24 | Entry remote IRR flags |
| dest_id_o | output | 24x8 | Entry destination IDs |

## Verification
Writes, side-band updates and busy sampling all land on the one clock edge that follows them. Read data has no delay, so a read sampled after that edge reflects the update. Each bench task drives its stimulus at a falling edge and holds it across exactly one rising edge. It then reads back at a later falling edge, one time unit after the address settles, and compares against values computed from the field layout. Priority cases apply the side-band pulse and the bus write in the same cycle, so both resolve on the same edge.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam logic [7:0]  OFF_SEL  = 8'h00;
  localparam logic [7:0]  OFF_WIN  = 8'h10;
  localparam logic [7:0]  SEL_ID   = 8'h00;
  localparam logic [7:0]  SEL_VER  = 8'h01;
  localparam logic [7:0]  SEL_ARB  = 8'h02;
  localparam logic [7:0]  SEL_TBL  = 8'h10;
  localparam logic [31:0] VER_WORD = 32'h0017_0011;
  localparam int B_DSTAT = 12;
  localparam int B_POL   = 13;
  localparam int B_RIRR  = 14;
  localparam int B_TRIG  = 15;
  localparam int B_MASK  = 16;

  typedef enum logic [2:0] {K_ID, K_VER, K_ZERO, K_ENT, K_BAD} sel_kind_e;
endpackage

// File: rtl/irq_sel_decode.sv
module irq_sel_decode
  import irq_redir_pkg::*;
#(
  parameter int N_ENT = 24,
  parameter int SEL_W = 8,
  localparam int IDX_W = SEL_W - 1
) (
  input  logic [SEL_W-1:0] sel_i,
  output sel_kind_e        kind_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hi_o
);
  always_comb begin
    idx_o = sel_i[SEL_W-1:1] - IDX_W'(SEL_TBL >> 1);
    hi_o  = sel_i[0];
    if (sel_i < SEL_W'(SEL_TBL)) begin
      if (sel_i == SEL_W'(SEL_ID) || sel_i == SEL_W'(SEL_ARB)) kind_o = K_ID;
      else if (sel_i == SEL_W'(SEL_VER))                       kind_o = K_VER;
      else                                                     kind_o = K_ZERO;
    end else if (idx_o < IDX_W'(N_ENT)) begin
      kind_o = K_ENT;
    end else begin
      kind_o = K_BAD;
    end
  end
endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
  import irq_redir_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  input  logic        rirr_set_i,
  input  logic        rirr_clr_i,
  input  logic        busy_i,
  output logic [31:0] lo_o,
  output logic [31:0] hi_o,
  output logic [7:0]  vector_o,
  output logic [2:0]  dlv_mode_o,
  output logic        dest_mode_o,
  output logic        polarity_o,
  output logic        level_o,
  output logic        mask_o,
  output logic        rirr_o,
  output logic [7:0]  dest_id_o
);
  logic [7:0] vec_q, dest_q;
  logic [2:0] dlv_q;
  logic       dmode_q, pol_q, trig_q, mask_q, dstat_q, rirr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q   <= '0;
      dlv_q   <= '0;
      dmode_q <= 1'b0;
      pol_q   <= 1'b0;
      trig_q  <= 1'b0;
      mask_q  <= 1'b1;
      dest_q  <= '0;
      dstat_q <= 1'b0;
      rirr_q  <= 1'b0;
    end else begin
      if (wr_lo_i) begin
        vec_q   <= wdata_i[7:0];
        dlv_q   <= wdata_i[10:8];
        dmode_q <= wdata_i[11];
        pol_q   <= wdata_i[B_POL];
        trig_q  <= wdata_i[B_TRIG];
        mask_q  <= wdata_i[B_MASK];
      end
      if (wr_hi_i) dest_q <= wdata_i[31:24];
      dstat_q <= busy_i;
      // side-band wins over the edge-mode clear
      if (rirr_set_i)                         rirr_q <= 1'b1;
      else if (rirr_clr_i)                    rirr_q <= 1'b0;
      else if (wr_lo_i && !wdata_i[B_TRIG])   rirr_q <= 1'b0;
    end
  end

  assign lo_o = {15'b0, mask_q, trig_q, rirr_q, pol_q, dstat_q, dmode_q, dlv_q, vec_q};
  assign hi_o = {dest_q, 24'b0};
  assign vector_o    = vec_q;
  assign dlv_mode_o  = dlv_q;
  assign dest_mode_o = dmode_q;
  assign polarity_o  = pol_q;
  assign level_o     = trig_q;
  assign mask_o      = mask_q;
  assign rirr_o      = rirr_q;
  assign dest_id_o   = dest_q;

  // R10
  rirr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rirr_set_i |=> rirr_o);
  // R10
  rirr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rirr_clr_i && !rirr_set_i) |=> !rirr_o);
  // R7
  rirr_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wdata_i[B_TRIG] && !rirr_set_i) |=> !rirr_o);
  // R7
  rirr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rirr_set_i && !rirr_clr_i && !(wr_lo_i && !wdata_i[B_TRIG])) |=> $stable(rirr_o));
  // R11
  dstat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> lo_o[B_DSTAT]);
  // R9
  fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_lo_i |=> ($stable(vector_o) && $stable(mask_o) && $stable(level_o)));
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int N_ENT = 24,
  parameter int SEL_W = 8,
  localparam int IDX_W = SEL_W - 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_valid_i,
  input  logic                  bus_write_i,
  input  logic [7:0]            bus_addr_i,
  input  logic [3:0]            bus_be_i,
  input  logic [31:0]           bus_wdata_i,
  output logic [31:0]           bus_rdata_o,
  input  logic [N_ENT-1:0]      rirr_set_i,
  input  logic [N_ENT-1:0]      rirr_clr_i,
  input  logic [N_ENT-1:0]      busy_i,
  output logic [N_ENT-1:0][7:0] vector_o,
  output logic [N_ENT-1:0][2:0] dlv_mode_o,
  output logic [N_ENT-1:0]      dest_mode_o,
  output logic [N_ENT-1:0]      polarity_o,
  output logic [N_ENT-1:0]      level_o,
  output logic [N_ENT-1:0]      mask_o,
  output logic [N_ENT-1:0]      rirr_o,
  output logic [N_ENT-1:0][7:0] dest_id_o
);
  logic [SEL_W-1:0] sel_q;
  logic [3:0]       id_q;
  sel_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic             hi;
  logic [31:0]      lo_w [N_ENT];
  logic [31:0]      hi_w [N_ENT];
  logic             wr_acc, sel_wr, win_wr;

  assign wr_acc = bus_valid_i && bus_write_i;
  assign sel_wr = wr_acc && bus_addr_i == OFF_SEL && bus_be_i[0];
  assign win_wr = wr_acc && bus_addr_i == OFF_WIN && bus_be_i == 4'hF;

  irq_sel_decode #(.N_ENT(N_ENT), .SEL_W(SEL_W)) u_dec (
    .sel_i(sel_q), .kind_o(kind), .idx_o(idx), .hi_o(hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr) sel_q <= bus_wdata_i[SEL_W-1:0];
      if (win_wr && sel_q == SEL_W'(SEL_ID)) id_q <= bus_wdata_i[27:24];
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic hit;
    assign hit = win_wr && kind == K_ENT && idx == IDX_W'(g);
    irq_redir_entry u_ent (
      .clk_i, .rst_ni,
      .wr_lo_i(hit && !hi), .wr_hi_i(hit && hi), .wdata_i(bus_wdata_i),
      .rirr_set_i(rirr_set_i[g]), .rirr_clr_i(rirr_clr_i[g]), .busy_i(busy_i[g]),
      .lo_o(lo_w[g]), .hi_o(hi_w[g]),
      .vector_o(vector_o[g]), .dlv_mode_o(dlv_mode_o[g]), .dest_mode_o(dest_mode_o[g]),
      .polarity_o(polarity_o[g]), .level_o(level_o[g]), .mask_o(mask_o[g]),
      .rirr_o(rirr_o[g]), .dest_id_o(dest_id_o[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == OFF_SEL) begin
      bus_rdata_o = 32'(sel_q);
    end else if (bus_addr_i == OFF_WIN) begin
      case (kind)
        K_ID:    bus_rdata_o = {4'b0, id_q, 24'b0};
        K_VER:   bus_rdata_o = VER_WORD;
        K_ENT:   bus_rdata_o = hi ? hi_w[idx] : lo_w[idx];
        K_BAD:   bus_rdata_o = '1;
        default: bus_rdata_o = '0;
      endcase
    end
  end

  // R1
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_wr |=> $stable(sel_q));
  // R3
  id_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(win_wr && sel_q == SEL_W'(SEL_ID)) |=> $stable(id_q));
  // R5
  bad_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFF_WIN && kind == K_BAD) |-> bus_rdata_o == '1);
  // R2
  ver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFF_WIN && sel_q == SEL_W'(SEL_VER)) |-> bus_rdata_o == VER_WORD);
endmodule

// File: tb/irq_redir_regs_test.sv
`timescale 1ns/1ps
module irq_redir_regs_test;
  localparam int N = 24;
  logic clk = 0, rst_n = 0;
  logic valid = 0, write = 0;
  logic [7:0] addr = 0;
  logic [3:0] be = 0;
  logic [31:0] wdata = 0, rdata;
  logic [N-1:0] rset = 0, rclr = 0, busy = 0;
  logic [N-1:0][7:0] vec, did;
  logic [N-1:0][2:0] dlv;
  logic [N-1:0] dmode, pol, lvl, msk, rirr;
  int checks = 0, errors = 0;
  logic [31:0] r;

  always #4 clk = ~clk;

  irq_redir_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rirr_set_i(rset), .rirr_clr_i(rclr), .busy_i(busy),
    .vector_o(vec), .dlv_mode_o(dlv), .dest_mode_o(dmode), .polarity_o(pol),
    .level_o(lvl), .mask_o(msk), .rirr_o(rirr), .dest_id_o(did)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    valid = 1; write = 1; addr = a; wdata = d; be = b;
    @(negedge clk);
    valid = 0; write = 0; be = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    valid = 1; write = 0; addr = a;
    #1 d = rdata;
    valid = 0;
  endtask

  task automatic rd_sel(input logic [7:0] s, output logic [31:0] d);
    wr(8'h00, 32'(s), 4'h1);
    rd(8'h10, d);
  endtask

  task automatic wr_sel(input logic [7:0] s, input logic [31:0] d);
    wr(8'h00, 32'(s), 4'h1);
    wr(8'h10, d, 4'hF);
  endtask

  task automatic t_reset;
    rd(8'h00, r);          chk("R8 select", r, 0);
    rd(8'h10, r);          chk("R8 id", r, 0);
    rd_sel(8'h10, r);      chk("R8 entry0 lo", r, 32'h0001_0000);
    rd_sel(8'h3F, r);      chk("R8 entry23 hi", r, 0);
    chk("R8 mask ports", 32'(msk), 32'h00FF_FFFF);
    chk("R8 rirr ports", 32'(rirr), 0);
  endtask

  task automatic t_select;
    wr(8'h00, 32'hFFFF_FFA5, 4'h1);
    rd(8'h00, r);          chk("R1 select readback", r, 32'hA5);
    wr(8'h00, 32'h33, 4'h2);
    rd(8'h00, r);          chk("R1 select be0 gate", r, 32'hA5);
    wr(8'h04, 32'h1234_5678, 4'hF);
    rd(8'h04, r);          chk("R1 pad reads zero", r, 0);
    rd(8'h00, r);          chk("R1 pad write ignored", r, 32'hA5);
    rd(8'h08, r);          chk("R1 other offset zero", r, 0);
  endtask

  task automatic t_ver_id;
    rd_sel(8'h01, r);      chk("R2 version", r, 32'h0017_0011);
    wr(8'h10, 32'hFFE8_FFEE, 4'hF);
    rd(8'h10, r);          chk("R2 version ro", r, 32'h0017_0011);
    wr_sel(8'h00, 32'h1F3E_5D7C);
    rd(8'h10, r);          chk("R3 id bits", r, 32'h0F00_0000);
    rd_sel(8'h02, r);      chk("R3 arb mirror", r, 32'h0F00_0000);
    wr(8'h10, 32'h0000_0000, 4'hF);
    rd(8'h10, r);          chk("R3 arb ro", r, 32'h0F00_0000);
  endtask

  task automatic t_entries;
    wr_sel(8'h1A, 32'hFFFE_FE5F);
    rd(8'h10, r);          chk("R6 R7 entry5 lo", r, 32'h0000_AE5F);
    chk("R6 vector port", 32'(vec[5]), 32'h5F);
    chk("R6 dlv port", 32'(dlv[5]), 6);
    chk("R6 flag ports", {28'b0, dmode[5], pol[5], lvl[5], msk[5]}, 32'hE);
    wr_sel(8'h1B, 32'hC3FF_FFFF);
    rd(8'h10, r);          chk("R4 R6 entry5 hi", r, 32'hC300_0000);
    chk("R6 dest port", 32'(did[5]), 32'hC3);
    rd_sel(8'h1A, r);      chk("R4 lo unaffected by hi", r, 32'h0000_AE5F);
    wr_sel(8'h3E, 32'h0000_0077);
    rd(8'h10, r);          chk("R4 entry23 lo", r, 32'h77);
    chk("R4 entry23 port", {23'b0, msk[23], vec[23]}, 32'h77);
  endtask

  task automatic t_unused;
    wr_sel(8'h05, 32'hFFFF_FFFF);
    rd(8'h10, r);          chk("R5 low unused zero", r, 0);
    rd_sel(8'h00, r);      chk("R5 low unused no write", r, 32'h0F00_0000);
    wr_sel(8'h40, 32'h0000_0000);
    rd(8'h10, r);          chk("R5 index24 ones", r, 32'hFFFF_FFFF);
    rd_sel(8'h10, r);      chk("R5 bad idx no write", r, 32'h0001_0000);
    rd_sel(8'hFF, r);      chk("R5 sel ff ones", r, 32'hFFFF_FFFF);
  endtask

  task automatic t_partial;
    wr(8'h00, 32'h1A, 4'h1);
    wr(8'h10, 32'h0001_0000, 4'h7);
    rd(8'h10, r);          chk("R9 partial dropped", r, 32'h0000_AE5F);
    wr(8'h10, 32'h0001_0000, 4'h0);
    chk("R9 mask port", 32'(msk[5]), 0);
  endtask

  task automatic t_rirr;
    @(negedge clk); rset[5] = 1;
    @(negedge clk); rset[5] = 0;
    chk("R10 set port", 32'(rirr[5]), 1);
    wr_sel(8'h1A, 32'h0000_8011);
    rd(8'h10, r);          chk("R7 level write keeps rirr", r, 32'h0000_C011);
    wr(8'h10, 32'h0000_0011, 4'hF);
    rd(8'h10, r);          chk("R7 edge write clears rirr", r, 32'h0000_0011);
    @(negedge clk); rset[5] = 1; rclr[5] = 1;
    @(negedge clk); rset[5] = 0; rclr[5] = 0;
    chk("R10 set wins clear", 32'(rirr[5]), 1);
    @(negedge clk); rclr[5] = 1;
    @(negedge clk); rclr[5] = 0;
    chk("R10 clear", 32'(rirr[5]), 0);
    @(negedge clk); rset[5] = 1; valid = 1; write = 1; addr = 8'h10; wdata = 32'h22; be = 4'hF;
    @(negedge clk); rset[5] = 0; valid = 0; write = 0; be = 0;
    rd(8'h10, r);          chk("R10 set beats edge write", r, 32'h0000_4022);
    chk("R10 other entries", 32'(rirr) & 32'hFFFF_FFDF, 0);
  endtask

  task automatic t_busy;
    wr(8'h10, 32'h0000_1022, 4'hF);
    rd(8'h10, r);          chk("R11 dstat not writable", r & 32'h1000, 0);
    @(negedge clk); busy[5] = 1;
    @(negedge clk);
    rd(8'h10, r);          chk("R11 dstat follows busy", r & 32'h1000, 32'h1000);
    @(negedge clk); busy[5] = 0;
    @(negedge clk);
    wr(8'h10, 32'h0000_1022, 4'hF);
    rd(8'h10, r);          chk("R11 dstat drops", r & 32'h1000, 0);
  endtask

  initial begin
    #20 rst_n = 1;
    t_reset;
    t_select;
    t_ver_id;
    t_entries;
    t_unused;
    t_partial;
    t_rirr;
    t_busy;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule